// File: doc/BRIEF.md
# Serial Result Readout Port with Ready Flag and Check Byte

This block is the device side of a read-only, two-wire serial port. The host drives only a serial clock. The block drives one output line that does two jobs. When no transfer is running it is a data-ready flag. During a transfer it carries the data bits. Each new 24-bit conversion result arrives as a one-cycle strobe. The block holds the result and pulls the line low to say that a result is waiting.

On each rising edge of the host clock, the block sends the next bit of a 32-bit frame, most significant bit first. The frame is the result's upper, middle and lower bytes, followed by a check byte. The check byte comes from the 8-bit sum of the three bytes plus a fixed seed, with both of its outer bits forced to one. If the host keeps clocking after the frame, the frame repeats from the upper byte.

If the host clock is high when a result strobe arrives, the block enters a low-power standby state. It leaves standby when the host clock goes low again. On exit it sends a one-cycle restart request to the decimation filter. It then discards results until the filter has settled.

Top module: `sdo_ready_port`

## Requirements
- R1: After reset, `dout_rdy_n` is 1 and `standby` and `restart_req` are 0.
- R2: A result strobe that is accepted drives `dout_rdy_n` to 1 in the cycle after the strobe. It drives `dout_rdy_n` to 0 one cycle later, and the line stays 0 until the first rising edge of the serial clock.
- R3: Each synchronised rising edge of `sclk_in` presents the next frame bit, most significant bit first. Bit 31 is result bit 23 and bit 8 is result bit 0.
- R4: Frame bits 7:0 are the check byte. Let s = (result[23:16] + result[15:8] + result[7:0] + 8'h5B) mod 256. The check byte is {1, s[6:1], 1}.
- R5: After the 32nd bit, the next rising edge presents frame bit 31 again, and the frame repeats.
- R6: A result strobe that arrives during a read while `sclk_in` is low drops the partial read. The new result then follows R2 and R3 from frame bit 31.
- R7: A result strobe that arrives while the synchronised `sclk_in` is high sets `standby` to 1, keeps `dout_rdy_n` at 1, and does not load the result.
- R8: Result strobes during standby are ignored, and `dout_rdy_n` stays 1.
- R9: In standby, a low level on the synchronised `sclk_in` clears `standby` and raises `restart_req` for exactly one cycle.
- R10: After a standby exit, the first three result strobes are discarded and `dout_rdy_n` stays 1. The fourth strobe is accepted as in R2.
- R11: Rising edges of the serial clock when no result is held leave `dout_rdy_n` at 1.
- R12: Falling edges of the serial clock do not change `dout_rdy_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_valid | input | 1 | One-cycle strobe: a new result is available |
| conv_data | input | 24 | Two's complement conversion result |
| sclk_in | input | 1 | Host serial clock, asynchronous to `clk` |
| dout_rdy_n | output | 1 | Serial data out; low when idle means a result is ready |
| standby | output | 1 | High while the port is in standby |
| restart_req | output | 1 | One-cycle pulse to the filter on standby exit |

## Verification
Random results are each read as a full frame, followed by a random number of extra bits. These reads separate a correct bit order, check byte and wrap from a wrong shift direction, a wrong sum, an unforced end bit or a wrap to the wrong point. Directed results of all zeros and all ones test the carry out of the 8-bit sum and the forced end bits. A strobe that arrives in the middle of a read shows that the sequence restarts on the new result. Clock pulses with no result loaded, a strobe with the clock high, strobes during standby and the discarded strobes after exit each show that the output holds where it should not move.

// File: rtl/rdout_pkg.sv
package rdout_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned DATA_BYTES = 3;
  localparam int unsigned DATA_W     = BYTE_W * DATA_BYTES;
  localparam int unsigned FRAME_W    = DATA_W + BYTE_W;
  localparam int unsigned IDX_W      = $clog2(FRAME_W);
  localparam logic [BYTE_W-1:0] CHECK_SEED = 8'h5B;

  typedef enum logic [2:0] {
    ST_EMPTY,
    ST_UPDATE,
    ST_READY,
    ST_READ,
    ST_STANDBY
  } port_state_e;

  // Seeded modulo-256 sum of the result bytes
  function automatic logic [BYTE_W-1:0] seeded_sum(input logic [DATA_W-1:0] d);
    logic [BYTE_W-1:0] acc;
    acc = CHECK_SEED;
    for (int i = 0; i < int'(DATA_BYTES); i++) begin
      acc = acc + d[i*BYTE_W +: BYTE_W];
    end
    return acc;
  endfunction

  // Check byte: sum bits 6..1 framed by forced ones
  function automatic logic [BYTE_W-1:0] check_byte(input logic [DATA_W-1:0] d);
    logic [BYTE_W-1:0] s;
    s = seeded_sum(d);
    return {1'b1, s[BYTE_W-2:1], 1'b1};
  endfunction
endpackage

// File: rtl/sclk_sync.sv
module sclk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  output logic sclk_lvl,
  output logic sclk_rise
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-1:0], sclk_in};
  end

  assign sclk_lvl  = pipe_q[STAGES-1];
  assign sclk_rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  // R3: one host edge yields a single shift event
  assert_single_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> !sclk_rise);
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
  import rdout_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift_en,
  output logic              cur_bit
);
  logic [DATA_W-1:0]  shadow_q;
  logic [IDX_W-1:0]   idx_q;
  logic [FRAME_W-1:0] frame;
  logic               idx_last;

  assign frame    = {shadow_q, check_byte(shadow_q)};
  assign idx_last = (idx_q == IDX_W'(FRAME_W - 1));
  assign cur_bit  = frame[IDX_W'(FRAME_W - 1) - idx_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      idx_q    <= '0;
    end else if (load_en) begin
      shadow_q <= load_data;
      idx_q    <= '0;
    end else if (shift_en) begin
      idx_q <= idx_last ? '0 : idx_q + 1'b1;
    end
  end

  // R5: the frame wraps to its first bit
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load_en && idx_last) |=> (idx_q == '0));
  // R8: the held result only changes on an accepted load
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(shadow_q));
endmodule

// File: rtl/readout_ctrl.sv
module readout_ctrl
  import rdout_pkg::*;
#(
  parameter int unsigned SETTLE_UPDATES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_valid,
  input  logic sclk_lvl,
  input  logic sclk_rise,
  input  logic cur_bit,
  output logic load_en,
  output logic shift_en,
  output logic dout_q,
  output logic standby_q,
  output logic restart_q
);
  localparam int unsigned CNT_W = $clog2(SETTLE_UPDATES + 1);
  localparam logic [CNT_W-1:0] SETTLE_RELOAD = CNT_W'(SETTLE_UPDATES - 1);

  port_state_e      st_q, st_d;
  logic [CNT_W-1:0] settle_q, settle_d;
  logic             dout_d, restart_d;

  always_comb begin
    st_d      = st_q;
    settle_d  = settle_q;
    dout_d    = dout_q;
    restart_d = 1'b0;
    load_en   = 1'b0;
    shift_en  = 1'b0;
    if (st_q == ST_STANDBY) begin
      if (!sclk_lvl) begin
        st_d      = ST_EMPTY;
        restart_d = 1'b1;
        settle_d  = SETTLE_RELOAD;
      end
    end else if (conv_valid) begin
      dout_d = 1'b1;
      if (sclk_lvl) begin
        st_d = ST_STANDBY;
      end else if (settle_q != '0) begin
        settle_d = settle_q - 1'b1;
        st_d     = ST_EMPTY;
      end else begin
        load_en = 1'b1;
        st_d    = ST_UPDATE;
      end
    end else begin
      case (st_q)
        ST_UPDATE: begin
          st_d   = ST_READY;
          dout_d = 1'b0;
        end
        ST_READY, ST_READ: begin
          if (sclk_rise) begin
            shift_en = 1'b1;
            dout_d   = cur_bit;
            st_d     = ST_READ;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_EMPTY;
      settle_q  <= '0;
      dout_q    <= 1'b1;
      restart_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      settle_q  <= settle_d;
      dout_q    <= dout_d;
      restart_q <= restart_d;
    end
  end

  assign standby_q = (st_q == ST_STANDBY);

  // R2: a waiting result is flagged by a low line
  assert_ready_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_READY) |-> !dout_q);
  // R7: a strobe with the clock high never loads the result
  assert_no_load_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && sclk_lvl) |-> !load_en);
endmodule

// File: rtl/sdo_ready_port.sv
module sdo_ready_port
  import rdout_pkg::*;
#(
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned SETTLE_UPDATES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_valid,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              sclk_in,
  output logic              dout_rdy_n,
  output logic              standby,
  output logic              restart_req
);
  logic sclk_lvl, sclk_rise;
  logic load_en, shift_en, cur_bit;

  sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in),
    .sclk_lvl(sclk_lvl), .sclk_rise(sclk_rise)
  );

  frame_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_data(conv_data),
    .shift_en(shift_en), .cur_bit(cur_bit)
  );

  readout_ctrl #(.SETTLE_UPDATES(SETTLE_UPDATES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid),
    .sclk_lvl(sclk_lvl), .sclk_rise(sclk_rise), .cur_bit(cur_bit),
    .load_en(load_en), .shift_en(shift_en), .dout_q(dout_rdy_n),
    .standby_q(standby), .restart_q(restart_req)
  );

  // R7: standby keeps the line high
  assert_standby_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> dout_rdy_n);
  // R9: restart only on the exit from standby
  assert_restart_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |-> (!standby && $past(standby)));
  // R9: restart lasts one cycle
  assert_restart_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |=> !restart_req);
endmodule

// File: tb/sdo_ready_port_bench.sv
module sdo_ready_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_valid = 1'b0;
  logic [23:0] conv_data = '0;
  logic        sclk_in = 1'b0;
  logic        dout_rdy_n, standby, restart_req;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  sdo_ready_port u_sdo_ready_port (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_data(conv_data),
    .sclk_in(sclk_in), .dout_rdy_n(dout_rdy_n), .standby(standby),
    .restart_req(restart_req)
  );

  function automatic logic [31:0] exp_frame(input logic [23:0] d);
    logic [7:0] c;
    c = d[23:16] + d[15:8] + d[7:0] + 8'h5B;
    return {d, (c & 8'h7E) | 8'h81};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [23:0] d);
    @(negedge clk);
    conv_data  = d;
    conv_valid = 1'b1;
    @(negedge clk);
    conv_valid = 1'b0;
  endtask

  // accepted strobe: high for one cycle, then low
  task automatic load_ready(input logic [23:0] d, input string req);
    strobe(d);
    chk(req, 32'(dout_rdy_n), 32'd1);
    @(negedge clk);
    chk(req, 32'(dout_rdy_n), 32'd0);
  endtask

  // one host clock pulse; returns the line after the rise, checks it after the fall
  task automatic pulse(output logic b);
    @(negedge clk);
    sclk_in = 1'b1;
    repeat (4) @(negedge clk);
    b = dout_rdy_n;
    sclk_in = 1'b0;
    repeat (4) @(negedge clk);
    chk("R12", 32'(dout_rdy_n), 32'(b));
  endtask

  task automatic read_bits(input logic [31:0] f, input int n, input string req);
    logic b;
    for (int i = 0; i < n; i++) begin
      pulse(b);
      chk(req, 32'(b), 32'(f[31 - (i % 32)]));
    end
  endtask

  initial begin
    logic [23:0] d;
    logic b;
    int seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", {29'd0, dout_rdy_n, standby, restart_req}, 32'h4);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", {29'd0, dout_rdy_n, standby, restart_req}, 32'h4);
    // R11: clocks with nothing loaded
    for (int i = 0; i < 3; i++) begin
      pulse(b);
      chk("R11", 32'(b), 32'd1);
    end
    // R4: directed check bytes, carry and forced ends
    load_ready(24'h000000, "R2");
    read_bits(exp_frame(24'h000000), 32, "R4");
    load_ready(24'hFFFFFF, "R2");
    read_bits(exp_frame(24'hFFFFFF), 32, "R4");
    // R3/R5: random results with wrap
    for (int k = 0; k < 20; k++) begin
      d = 24'($urandom);
      load_ready(d, "R2");
      read_bits(exp_frame(d), 32 + int'($urandom_range(0, 8)), "R5");
    end
    d = 24'h8C31A7;
    load_ready(d, "R2");
    read_bits(exp_frame(d), 24, "R3");
    // R6: strobe during a read restarts the frame
    d = 24'h123456;
    load_ready(d, "R2");
    read_bits(exp_frame(d), 10, "R3");
    d = 24'hA5C3E1;
    load_ready(d, "R6");
    read_bits(exp_frame(d), 32, "R6");
    // R7: strobe with clock high enters standby
    @(negedge clk);
    sclk_in = 1'b1;
    repeat (4) @(negedge clk);
    strobe(24'h0F0F0F);
    chk("R7", {30'd0, standby, dout_rdy_n}, 32'h3);
    // R8: strobes in standby ignored
    strobe(24'h111111);
    @(negedge clk);
    chk("R8", {30'd0, standby, dout_rdy_n}, 32'h3);
    // R9: exit on clock low
    sclk_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", {30'd0, standby, restart_req}, 32'h1);
    @(negedge clk);
    chk("R9", {30'd0, standby, restart_req}, 32'h0);
    // R10: three discarded results, then the fourth accepted
    for (int i = 0; i < 3; i++) begin
      strobe(24'h222222);
      @(negedge clk);
      chk("R10", 32'(dout_rdy_n), 32'd1);
    end
    d = 24'h3C5A7E;
    load_ready(d, "R10");
    read_bits(exp_frame(d), 32, "R10");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule